// File: doc/BRIEF.md
# PRBS Pattern Generator and Synchronizing Checker

This block drives and checks a maximal-length pseudo-random test pattern for E1 or T1 line testing. The pattern is one bit per clock. A mode input picks between a 15-stage sequence for E1 and a 20-stage sequence for T1. The transmit side produces pattern bits only while its enable input is high.

The receive side watches a serial data input on every clock, whatever the transmit enable is doing. While it hunts, it seeds its reference register from the incoming bits. After 64 consecutive bits that match its prediction, it declares lock. From then on it free-runs its reference, so one corrupted bit produces one error. It drops back to hunting when six or more errors fall inside the most recent 64 received bits.

The error output stays high during the hunt and pulses once per bit error while locked. A sticky status flag records that lock was reached. When counting is enabled, a separate one-cycle strobe per locked error can feed an external error counter.

Top module: `prbs_tester`

## Requirements
- R1: With `modeT1`=0 the transmitted bits obey b[i] = b[i-15] xor b[i-14] (polynomial x^15+x^14+1). With `modeT1`=1 they obey b[i] = b[i-20] xor b[i-17] (x^20+x^17+1). The sequence is never all zero.
- R2: While `txEnable` is 0, `txData` is 0 on the following cycle.
- R3: The checker hunts whether or not `txEnable` is set. `errOut` is 1 during the hunt and for at least the first 63 received bits after reset. It falls to 0 one cycle after the 64th consecutive correctly predicted bit.
- R4: `syncFlag` is set when lock is reached and stays set after lock is lost. It is cleared only by reset or by a mode change.
- R5: While locked, each received bit that differs from the prediction makes `errOut` high for exactly one cycle, on the cycle after that bit is sampled.
- R6: While locked, the checker returns to hunting when the current bit and the 63 before it contain 6 or more errors. With 5 or fewer such errors it stays locked.
- R7: `errStrobe` pulses once, for one cycle, for each locked error when `countEnable` is 1. It stays 0 when `countEnable` is 0 and while hunting.
- R8: A change of `modeT1` forces hunting. On the next cycle `syncFlag` is 0 and `errOut` is 1.
- R9: A constant-zero input never achieves lock.
- R10: During reset `errOut` is 1, and `syncFlag`, `errStrobe` and `txData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| txEnable | input | 1 | Enables pattern transmission |
| modeT1 | input | 1 | 0 selects the 15-stage pattern, 1 selects the 20-stage pattern |
| countEnable | input | 1 | Gates the per-error counter strobe |
| rxData | input | 1 | Received serial bit |
| txData | output | 1 | Transmitted pattern bit |
| errOut | output | 1 | High while hunting; one-cycle pulse per error while locked |
| syncFlag | output | 1 | Sticky lock indication |
| errStrobe | output | 1 | One-cycle strobe per locked error for an external counter |

## Verification
Suppose the reference register were seeded or advanced wrongly. The checker would then either never lock on a clean pattern, leaving `errOut` high past bit 85, or report errors on clean bits within one cycle of lock. A corrupted error window shows up at the ports as a loss of lock at the wrong error count: five errors in a span would drop `errOut` into a steady high, or six errors would leave it pulsing. Either is visible by the bit after the last injected error. Errors spaced just over and just under the 64-bit span, with both pattern lengths, separate these cases.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic inSync;    // reference free-runs instead of self-seeding
    logic clearWin;  // error window held empty
    logic restart;   // mode changed: drop reference contents
  } ctrl_t;
endpackage

// File: rtl/prbs_datapath.sv
module prbs_datapath
  import prbs_pkg::*;
#(
  parameter int SHORT_LEN = 15,
  parameter int SHORT_TAP = 14,
  parameter int LONG_LEN  = 20,
  parameter int LONG_TAP  = 17,
  parameter int WINDOW    = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  txEnable,
  input  logic  modeT1,
  input  logic  rxData,
  input  ctrl_t ctrl,
  output logic  txData,
  output logic  bitErr,
  output logic  winOver
);
  localparam int W   = LONG_LEN;
  localparam int WCW = $clog2(WINDOW + 1);
  localparam logic [W-1:0] SHORT_MASK = {{(W-SHORT_LEN){1'b0}}, {SHORT_LEN{1'b1}}};
  localparam logic [W-1:0] LONG_MASK  = {W{1'b1}};

  function automatic logic feedback(input logic [W-1:0] s, input logic longMode);
    return longMode ? (s[LONG_LEN-1] ^ s[LONG_TAP-1]) : (s[SHORT_LEN-1] ^ s[SHORT_TAP-1]);
  endfunction

  logic [W-1:0] activeMask;
  assign activeMask = modeT1 ? LONG_MASK : SHORT_MASK;

  // Transmit generator
  logic [W-1:0] txLfsr;
  logic txZero, txBit;
  assign txZero = (txLfsr & activeMask) == '0;
  assign txBit  = txZero ? 1'b1 : feedback(txLfsr, modeT1);

  always_ff @(posedge clk) begin
    if (rst) begin
      txLfsr <= '1;
      txData <= 1'b0;
    end else begin
      if (txEnable) txLfsr <= {txLfsr[W-2:0], txBit};
      txData <= txEnable & txBit;
    end
  end

  // Receive reference and prediction
  logic [W-1:0] refReg;
  logic predBit, refZero;
  assign predBit = feedback(refReg, modeT1);
  assign refZero = (refReg & activeMask) == '0;
  assign bitErr  = refZero | (rxData != predBit);

  always_ff @(posedge clk) begin
    if (rst || ctrl.restart) refReg <= '0;
    else refReg <= {refReg[W-2:0], ctrl.inSync ? predBit : rxData};
  end

  // Sliding error window with running population count
  logic [WINDOW-1:0] errHist;
  logic [WCW-1:0] winCount, winNext;
  assign winNext = winCount + WCW'(bitErr) - WCW'(errHist[WINDOW-1]);
  assign winOver = winNext >= WCW'(LOSS_ERRS);

  always_ff @(posedge clk) begin
    if (rst || ctrl.clearWin) begin
      errHist  <= '0;
      winCount <= '0;
    end else begin
      errHist  <= {errHist[WINDOW-2:0], bitErr};
      winCount <= winNext;
    end
  end

  assert_window_count_R6: assert property (@(posedge clk) disable iff (rst)
    int'(winCount) == $countones(errHist));
  assert_window_bound_R6: assert property (@(posedge clk) disable iff (rst)
    int'(winCount) <= LOSS_ERRS);
  assert_tx_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(txEnable) |-> !txData);
endmodule

// File: rtl/prbs_control.sv
module prbs_control
  import prbs_pkg::*;
#(
  parameter int SYNC_BITS = 64
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  modeT1,
  input  logic  countEnable,
  input  logic  bitErr,
  input  logic  winOver,
  output ctrl_t ctrl,
  output logic  errOut,
  output logic  syncFlag,
  output logic  errStrobe
);
  localparam int GCW = $clog2(SYNC_BITS);

  typedef enum logic {HUNT, LOCKED} state_t;
  state_t state, nextState;
  logic [GCW-1:0] goodCnt, goodNext;
  logic modeQ, restart;

  assign restart = modeT1 != modeQ;

  always_comb begin
    nextState = state;
    goodNext  = goodCnt;
    if (restart) begin
      nextState = HUNT;
      goodNext  = '0;
    end else if (state == HUNT) begin
      if (bitErr) goodNext = '0;
      else if (goodCnt == GCW'(SYNC_BITS - 1)) begin
        nextState = LOCKED;
        goodNext  = '0;
      end else goodNext = goodCnt + GCW'(1);
    end else if (winOver) begin
      nextState = HUNT;
    end
  end

  assign ctrl.inSync   = state == LOCKED;
  assign ctrl.clearWin = restart | (state != LOCKED);
  assign ctrl.restart  = restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= HUNT;
      goodCnt   <= '0;
      modeQ     <= modeT1;
      errOut    <= 1'b1;
      syncFlag  <= 1'b0;
      errStrobe <= 1'b0;
    end else begin
      state     <= nextState;
      goodCnt   <= goodNext;
      modeQ     <= modeT1;
      errOut    <= (nextState == HUNT) | (bitErr & (state == LOCKED));
      syncFlag  <= restart ? 1'b0 : (syncFlag | (nextState == LOCKED));
      errStrobe <= countEnable & bitErr & (state == LOCKED) & !restart;
    end
  end

  assert_hunt_err_high_R3: assert property (@(posedge clk) disable iff (rst)
    (state == HUNT) |-> errOut);
  assert_locked_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (state == LOCKED) |-> syncFlag);
  assert_strobe_after_lock_R7: assert property (@(posedge clk) disable iff (rst)
    errStrobe |-> (syncFlag && errOut));
  assert_mode_restart_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!syncFlag && errOut));
endmodule

// File: rtl/prbs_tester.sv
module prbs_tester
  import prbs_pkg::*;
#(
  parameter int SHORT_LEN = 15,
  parameter int SHORT_TAP = 14,
  parameter int LONG_LEN  = 20,
  parameter int LONG_TAP  = 17,
  parameter int SYNC_BITS = 64,
  parameter int WINDOW    = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic txEnable,
  input  logic modeT1,
  input  logic countEnable,
  input  logic rxData,
  output logic txData,
  output logic errOut,
  output logic syncFlag,
  output logic errStrobe
);
  ctrl_t ctrl;
  logic bitErr, winOver;

  prbs_datapath #(
    .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP),
    .LONG_LEN(LONG_LEN), .LONG_TAP(LONG_TAP),
    .WINDOW(WINDOW), .LOSS_ERRS(LOSS_ERRS)
  ) dp (
    .clk(clk), .rst(rst), .txEnable(txEnable), .modeT1(modeT1),
    .rxData(rxData), .ctrl(ctrl), .txData(txData),
    .bitErr(bitErr), .winOver(winOver)
  );

  prbs_control #(.SYNC_BITS(SYNC_BITS)) ctl (
    .clk(clk), .rst(rst), .modeT1(modeT1), .countEnable(countEnable),
    .bitErr(bitErr), .winOver(winOver), .ctrl(ctrl),
    .errOut(errOut), .syncFlag(syncFlag), .errStrobe(errStrobe)
  );
endmodule

// File: tb/prbs_tester_test.sv
module prbs_tester_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txEnable = 1'b0, modeT1 = 1'b0, countEnable = 1'b0, rxData = 1'b0;
  logic txData, errOut, syncFlag, errStrobe;
  int total = 0, bad = 0;
  logic [19:0] genState;
  logic genMode;

  always #4 clk = ~clk;

  prbs_tester uut (
    .clk(clk), .rst(rst), .txEnable(txEnable), .modeT1(modeT1),
    .countEnable(countEnable), .rxData(rxData), .txData(txData),
    .errOut(errOut), .syncFlag(syncFlag), .errStrobe(errStrobe)
  );

  // Row: {mode, errors[3:0], spacing[4:0], countEnable, expectLoss}
  localparam logic [11:0] ROWS [6] = '{
    {1'b0, 4'd3, 5'd10, 1'b1, 1'b0},
    {1'b0, 4'd6, 5'd10, 1'b1, 1'b1},
    {1'b1, 4'd5, 5'd5,  1'b1, 1'b0},
    {1'b1, 4'd6, 5'd12, 1'b1, 1'b1},
    {1'b0, 4'd6, 5'd14, 1'b1, 1'b0},
    {1'b1, 4'd4, 5'd9,  1'b0, 1'b0}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic genNext();
    logic b;
    b = genMode ? (genState[19] ^ genState[16]) : (genState[14] ^ genState[13]);
    genState = {genState[18:0], b};
    return b;
  endfunction

  task automatic sendBit(input logic flip);
    rxData = genNext() ^ flip;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int errPulses, strobes, hunted;
    logic [199:0] txBits;
    @(negedge clk);
    doReset();
    rst = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(errOut == 1'b1, "R10 errOut", errOut, 1);
    check(syncFlag == 1'b0, "R10 syncFlag", syncFlag, 0);
    check(errStrobe == 1'b0 && txData == 1'b0, "R10 strobe/txData", errStrobe | txData, 0);
    rst = 1'b0;

    // Table walk: R3 lock with txEnable=0, R5/R6/R7 error handling, R4 sticky
    for (int r = 0; r < 6; r++) begin
      logic rMode, rCen, rLoss;
      int rK, rSp;
      {rMode, rK, rSp, rCen, rLoss} = {ROWS[r][11], int'(ROWS[r][10:7]),
                                       int'(ROWS[r][6:2]), ROWS[r][1], ROWS[r][0]};
      modeT1 = rMode; genMode = rMode; countEnable = rCen;
      genState = 20'h1ACE5 ^ 20'(r * 37);
      doReset();
      hunted = 0;
      for (int i = 0; i < 100; i++) begin
        sendBit(1'b0);
        if (i < 63 && errOut != 1'b1) hunted++;
      end
      check(hunted == 0, "R3 errOut high during first 63 bits", hunted, 0);
      check(errOut == 1'b0 && syncFlag == 1'b1, "R3 locked after clean bits", {errOut, syncFlag}, 1);
      errPulses = 0; strobes = 0;
      for (int e = 0; e < rK; e++) begin
        sendBit(1'b1);
        errPulses += int'(errOut); strobes += int'(errStrobe);
        for (int s = 1; s < rSp; s++) begin
          sendBit(1'b0);
          errPulses += int'(errOut); strobes += int'(errStrobe);
        end
      end
      for (int t = 0; t < 10; t++) begin
        sendBit(1'b0);
        if (!rLoss) errPulses += int'(errOut);
        strobes += int'(errStrobe);
      end
      check(strobes == (rCen ? rK : 0), "R7 strobe count", strobes, rCen ? rK : 0);
      if (rLoss) begin
        check(errOut == 1'b1, "R6 lock lost at 6 errors in window", errOut, 1);
        check(syncFlag == 1'b1, "R4 flag sticky after loss", syncFlag, 1);
      end else begin
        check(errOut == 1'b0, "R6 lock held below threshold", errOut, 0);
        check(errPulses == rK, "R5 one errOut pulse per error", errPulses, rK);
      end
    end

    // R2 transmit disabled
    txEnable = 1'b0; modeT1 = 1'b0; countEnable = 1'b0;
    doReset();
    hunted = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      hunted += int'(txData);
    end
    check(hunted == 0, "R2 txData idle when disabled", hunted, 0);

    // R1 recurrence for both modes, looped back into the checker
    for (int m = 0; m < 2; m++) begin
      int viol, ones;
      modeT1 = m[0];
      doReset();
      txEnable = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 200; i++) begin
        txBits[i] = txData;
        rxData = txData;
        @(negedge clk);
      end
      viol = 0; ones = 0;
      for (int i = 20; i < 200; i++) begin
        ones += int'(txBits[i]);
        if (m == 0 && txBits[i] != (txBits[i-15] ^ txBits[i-14])) viol++;
        if (m == 1 && txBits[i] != (txBits[i-20] ^ txBits[i-17])) viol++;
      end
      check(viol == 0, "R1 tx recurrence", viol, 0);
      check(ones > 0, "R1 tx not all zero", ones, 1);
      check(syncFlag == 1'b1, "R1 loopback locks", syncFlag, 1);
      txEnable = 1'b0;
    end

    // R8 mode change while locked
    modeT1 = 1'b0; genMode = 1'b0; genState = 20'h00321;
    doReset();
    for (int i = 0; i < 100; i++) sendBit(1'b0);
    check(syncFlag == 1'b1, "R8 locked before mode change", syncFlag, 1);
    modeT1 = 1'b1;
    sendBit(1'b0);
    check(syncFlag == 1'b0, "R8 flag cleared by mode change", syncFlag, 0);
    check(errOut == 1'b1, "R8 hunting after mode change", errOut, 1);

    // R9 all-zero input never locks
    modeT1 = 1'b0;
    doReset();
    hunted = 0;
    rxData = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (errOut != 1'b1 || syncFlag) hunted++;
    end
    check(hunted == 0, "R9 zeros never lock", hunted, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule